// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits at the decode stage of a two-wide in-order pipeline. Each cycle it receives up to two decoded instructions in program order, in slot A (older) and slot B (younger). Each instruction carries a three-bit group code, and a three-bit class code that matters only for the complex group. The block decides whether slot A issues and whether slot B issues alongside it. It also keeps a decode-lock counter. While that counter is nonzero it raises a stall flag and blocks all issue.

Pairing is decided by shared resources. There is one integer execute unit, one branch address calculator, one load/store issue port and one first floating-point stage. Two instructions that both need the same one of these cannot issue together. A complex instruction takes both decode slots. Once it issues, it keeps decode locked for a class-specific number of cycles. A taken compound arithmetic-and-branch instruction pairs normally, but it locks decode in the cycle after it issues.

When only slot A issues, the caller is expected to present the unissued slot B instruction as slot A in the next cycle. The block holds no instruction storage of its own.

Top module: `pairchk_top`

## Requirements
- R1: Group codes are 0 = simple move/misc (MT), 1 = integer (EX), 2 = branch (BR), 3 = load/store (LS), 4 = floating-point (FE), 5 = complex (CO), 6 = taken compound arith-branch (ABR), 7 = reserved (treated as MT). Slot A issues whenever it is valid and the stall flag is low.
- R2: Slot B issues only when slot A issues in the same cycle and slot B is valid. An invalid slot A blocks a valid slot B.
- R3: A CO instruction never issues together with another instruction, whichever slot it is in.
- R4: Two instructions of the same group EX, BR, LS or FE never issue in the same cycle.
- R5: MT, ABR and reserved instructions pair with any non-CO instruction. Any two non-CO instructions from different groups pair.
- R6: A CO instruction in slot A holds decode for its full length, counting its issue cycle, so the stall flag stays high for length minus one cycles after it issues. The class codes and lengths are: 0 far jump/return = 2, 1 return-from-exception = 5, 2 subroutine call = 16, 3 procedure-register load/store = 2, 4 MAC-register transfer = 1.
- R7: CO class codes 5 to 7 hold decode for one cycle, so no stall follows.
- R8: An issued ABR instruction, in either slot, raises the stall flag for exactly the one cycle after its issue.
- R9: While the stall flag is high, neither slot issues. When the stall flag drops, a waiting valid slot A issues in that same cycle.
- R10: After reset the stall flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vldA | input | 1 | Slot A (older) holds an instruction |
| grpA | input | 3 | Slot A group code |
| clsA | input | 3 | Slot A complex class code |
| vldB | input | 1 | Slot B (younger) holds an instruction |
| grpB | input | 3 | Slot B group code |
| clsB | input | 3 | Slot B complex class code |
| issueFirst | output | 1 | Slot A issues this cycle |
| issueSecond | output | 1 | Slot B issues this cycle |
| stall | output | 1 | Decode is locked; nothing issues |

## Verification
The two issue outputs are combinational from the current slot inputs and the registered lock counter. The bench therefore drives each vector at a falling edge and samples a nanosecond later, within the same cycle. The stall flag is registered: a locking issue seen at one rising edge first shows up as stall high after that edge. The bench therefore counts stalled cycles from the falling edge that follows the issue, holding an MT instruction in slot A. It expects exactly length minus one such cycles, with no issue during them, and then checks that the waiting instruction issues in the first cycle the flag is low. Between pairing vectors the bench drains any lock, so that each vector starts with the counter at zero.

// File: rtl/pairchk_pkg.sv
package pairchk_pkg;
  localparam logic [2:0] GRP_MT  = 3'd0;
  localparam logic [2:0] GRP_EX  = 3'd1;
  localparam logic [2:0] GRP_BR  = 3'd2;
  localparam logic [2:0] GRP_LS  = 3'd3;
  localparam logic [2:0] GRP_FE  = 3'd4;
  localparam logic [2:0] GRP_CO  = 3'd5;
  localparam logic [2:0] GRP_ABR = 3'd6;

  localparam logic [2:0] CLS_FAR  = 3'd0;
  localparam logic [2:0] CLS_RTE  = 3'd1;
  localparam logic [2:0] CLS_CALL = 3'd2;
  localparam logic [2:0] CLS_PR   = 3'd3;
  localparam logic [2:0] CLS_MAC  = 3'd4;

  // strobes from pairing control to the lock datapath
  typedef struct packed {
    logic       coIssue;
    logic [2:0] coCls;
    logic       abrIssue;
  } lockStrobe_t;
endpackage

// File: rtl/pair_ctl.sv
module pair_ctl
  import pairchk_pkg::*;
#(
  // one bit per group code: set when the group owns a single shared unit
  parameter logic [7:0] SOLO_MASK = 8'b0001_1110
) (
  input  logic        vldA,
  input  logic [2:0]  grpA,
  input  logic [2:0]  clsA,
  input  logic        vldB,
  input  logic [2:0]  grpB,
  input  logic        lockBusy,
  output logic        issueFirst,
  output logic        issueSecond,
  output lockStrobe_t strobe
);
  logic unitClash;
  logic anyCo;

  always_comb begin
    unitClash   = (grpA == grpB) && SOLO_MASK[grpA];
    anyCo       = (grpA == GRP_CO) || (grpB == GRP_CO);
    issueFirst  = vldA && !lockBusy;
    issueSecond = issueFirst && vldB && !anyCo && !unitClash;

    strobe.coIssue  = issueFirst && (grpA == GRP_CO);
    strobe.coCls    = clsA;
    strobe.abrIssue = (issueFirst && (grpA == GRP_ABR)) ||
                      (issueSecond && (grpB == GRP_ABR));
  end
endmodule

// File: rtl/pair_lock.sv
module pair_lock
  import pairchk_pkg::*;
#(
  parameter int LEN_FAR  = 2,
  parameter int LEN_RTE  = 5,
  parameter int LEN_CALL = 16,
  parameter int LEN_PR   = 2,
  parameter int LEN_MAC  = 1,
  parameter int LEN_DEF  = 1,
  parameter int ABR_HOLD = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  lockStrobe_t strobe,
  output logic        lockBusy
);
  localparam int MAX_A   = (LEN_FAR > LEN_RTE) ? LEN_FAR : LEN_RTE;
  localparam int MAX_B   = (LEN_CALL > LEN_PR) ? LEN_CALL : LEN_PR;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_D   = (LEN_MAC > LEN_DEF) ? LEN_MAC : LEN_DEF;
  localparam int MAX_E   = (MAX_C > MAX_D) ? MAX_C : MAX_D;
  localparam int MAX_LEN = (MAX_E > ABR_HOLD) ? MAX_E : ABR_HOLD;
  localparam int CW      = $clog2(MAX_LEN + 1);

  logic [CW-1:0] lockCnt;
  logic [CW-1:0] coHold;

  // extra held cycles after the issue cycle
  always_comb begin
    unique case (strobe.coCls)
      CLS_FAR:  coHold = CW'(LEN_FAR - 1);
      CLS_RTE:  coHold = CW'(LEN_RTE - 1);
      CLS_CALL: coHold = CW'(LEN_CALL - 1);
      CLS_PR:   coHold = CW'(LEN_PR - 1);
      CLS_MAC:  coHold = CW'(LEN_MAC - 1);
      default:  coHold = CW'(LEN_DEF - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  lockCnt <= '0;
    else if (strobe.coIssue)    lockCnt <= coHold;
    else if (strobe.abrIssue)   lockCnt <= CW'(ABR_HOLD);
    else if (lockCnt != '0)     lockCnt <= lockCnt - 1'b1;
  end

  assign lockBusy = (lockCnt != '0);
endmodule

// File: rtl/pairchk_top.sv
module pairchk_top
  import pairchk_pkg::*;
#(
  parameter int LEN_FAR  = 2,
  parameter int LEN_RTE  = 5,
  parameter int LEN_CALL = 16,
  parameter int LEN_PR   = 2,
  parameter int LEN_MAC  = 1,
  parameter int LEN_DEF  = 1,
  parameter int ABR_HOLD = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vldA,
  input  logic [2:0] grpA,
  input  logic [2:0] clsA,
  input  logic       vldB,
  input  logic [2:0] grpB,
  input  logic [2:0] clsB,
  output logic       issueFirst,
  output logic       issueSecond,
  output logic       stall
);
  lockStrobe_t strobe;
  logic        lockBusy;
  logic        unusedClsB;

  // a younger CO never issues, so its class is not needed here
  assign unusedClsB = ^clsB;

  pair_ctl u_ctl (
    .vldA(vldA), .grpA(grpA), .clsA(clsA),
    .vldB(vldB), .grpB(grpB),
    .lockBusy(lockBusy),
    .issueFirst(issueFirst), .issueSecond(issueSecond),
    .strobe(strobe)
  );

  pair_lock #(
    .LEN_FAR(LEN_FAR), .LEN_RTE(LEN_RTE), .LEN_CALL(LEN_CALL),
    .LEN_PR(LEN_PR), .LEN_MAC(LEN_MAC), .LEN_DEF(LEN_DEF),
    .ABR_HOLD(ABR_HOLD)
  ) u_lock (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lockBusy(lockBusy)
  );

  assign stall = lockBusy;
endmodule

// File: rtl/pair_check.sv
module pair_check (
  input logic       clk,
  input logic       rstN,
  input logic       vldA,
  input logic [2:0] grpA,
  input logic [2:0] clsA,
  input logic       vldB,
  input logic [2:0] grpB,
  input logic       issueFirst,
  input logic       issueSecond,
  input logic       stall
);
  a_r1_first_goes: assert property (@(posedge clk) disable iff (!rstN)
    (vldA && !stall) |-> issueFirst);
  a_r2_in_order: assert property (@(posedge clk) disable iff (!rstN)
    issueSecond |-> (issueFirst && vldB));
  a_r3_co_alone: assert property (@(posedge clk) disable iff (!rstN)
    issueSecond |-> (grpA != 3'd5 && grpB != 3'd5));
  a_r4_unit_clash: assert property (@(posedge clk) disable iff (!rstN)
    (issueSecond && grpA == grpB) |-> !(grpA inside {3'd1, 3'd2, 3'd3, 3'd4}));
  a_r6_call_locks: assert property (@(posedge clk) disable iff (!rstN)
    (issueFirst && grpA == 3'd5 && clsA == 3'd2) |=> stall);
  a_r7_mac_free: assert property (@(posedge clk) disable iff (!rstN)
    (issueFirst && grpA == 3'd5 && clsA == 3'd4) |=> !stall);
  a_r8_abr_lock: assert property (@(posedge clk) disable iff (!rstN)
    (issueFirst && grpA == 3'd6) |=> stall);
  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (!issueFirst && !issueSecond));
endmodule

bind pairchk_top pair_check u_chk (
  .clk(clk), .rstN(rstN), .vldA(vldA), .grpA(grpA), .clsA(clsA),
  .vldB(vldB), .grpB(grpB), .issueFirst(issueFirst),
  .issueSecond(issueSecond), .stall(stall)
);

// File: tb/tb_pairchk_top.sv
module tb_pairchk_top;
  localparam logic [2:0] MT = 3'd0, EX = 3'd1, BR = 3'd2, LS = 3'd3,
                         FE = 3'd4, CO = 3'd5, AB = 3'd6, RS = 3'd7;
  localparam int NV = 17;
  // {vldA, grpA, clsA, vldB, grpB, clsB, expFirst, expSecond}
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, EX, 3'd0, 1'b1, EX, 3'd0, 1'b1, 1'b0}, // R4
    {1'b1, EX, 3'd0, 1'b1, MT, 3'd0, 1'b1, 1'b1}, // R5
    {1'b1, MT, 3'd0, 1'b1, EX, 3'd0, 1'b1, 1'b1}, // R5
    {1'b1, BR, 3'd0, 1'b1, BR, 3'd0, 1'b1, 1'b0}, // R4
    {1'b1, LS, 3'd0, 1'b1, LS, 3'd0, 1'b1, 1'b0}, // R4
    {1'b1, FE, 3'd0, 1'b1, FE, 3'd0, 1'b1, 1'b0}, // R4
    {1'b1, MT, 3'd0, 1'b1, MT, 3'd0, 1'b1, 1'b1}, // R5
    {1'b1, EX, 3'd0, 1'b1, LS, 3'd0, 1'b1, 1'b1}, // R5
    {1'b1, BR, 3'd0, 1'b1, FE, 3'd0, 1'b1, 1'b1}, // R5
    {1'b1, CO, 3'd4, 1'b1, MT, 3'd0, 1'b1, 1'b0}, // R3
    {1'b1, MT, 3'd0, 1'b1, CO, 3'd4, 1'b1, 1'b0}, // R3
    {1'b0, MT, 3'd0, 1'b1, EX, 3'd0, 1'b0, 1'b0}, // R2
    {1'b1, LS, 3'd0, 1'b1, EX, 3'd0, 1'b1, 1'b1}, // R5
    {1'b1, AB, 3'd0, 1'b1, BR, 3'd0, 1'b1, 1'b1}, // R5
    {1'b1, EX, 3'd0, 1'b0, EX, 3'd0, 1'b1, 1'b0}, // R2
    {1'b1, FE, 3'd0, 1'b1, LS, 3'd0, 1'b1, 1'b1}, // R5
    {1'b1, RS, 3'd0, 1'b1, RS, 3'd0, 1'b1, 1'b1}  // R1
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic vldA = 1'b0, vldB = 1'b0;
  logic [2:0] grpA = 3'd0, clsA = 3'd0, grpB = 3'd0, clsB = 3'd0;
  logic issueFirst, issueSecond, stall;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pairchk_top dut (
    .clk(clk), .rstN(rstN), .vldA(vldA), .grpA(grpA), .clsA(clsA),
    .vldB(vldB), .grpB(grpB), .clsB(clsB),
    .issueFirst(issueFirst), .issueSecond(issueSecond), .stall(stall)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    vldA = 1'b0; vldB = 1'b0;
    #1;
    for (int k = 0; k < 40 && stall; k++) begin
      @(negedge clk); #1;
    end
  endtask

  // issue one slot-A instruction, then hold an MT and count stalled cycles
  task automatic lockRun(input string req, input logic [2:0] g,
                         input logic [2:0] c, input int expStall);
    int cnt;
    bit leaked;
    @(negedge clk);
    vldA = 1'b1; grpA = g; clsA = c; vldB = 1'b0;
    #1;
    check({req, " issue"}, issueFirst, 1);
    @(negedge clk);
    grpA = MT; clsA = 3'd0;
    #1;
    cnt = 0; leaked = 1'b0;
    while (stall && cnt < 40) begin
      if (issueFirst || issueSecond) leaked = 1'b1;
      cnt++;
      @(negedge clk); #1;
    end
    check({req, " stall cycles"}, cnt, expStall);
    check("R9 nothing issues during stall", leaked, 0);
    check("R9 waiting slot A issues on release", issueFirst, 1);
    drain();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 stall low in reset", stall, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R10 stall low after reset", stall, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {vldA, grpA, clsA, vldB, grpB, clsB} = VEC[i][15:2];
      #1;
      check($sformatf("pairing R1 R2 R3 R4 R5 vec %0d", i),
            {30'd0, issueFirst, issueSecond}, {30'd0, VEC[i][1:0]});
      drain();
    end

    lockRun("R6 far jump",   CO, 3'd0, 1);
    lockRun("R6 rte",        CO, 3'd1, 4);
    lockRun("R6 call",       CO, 3'd2, 15);
    lockRun("R6 pr xfer",    CO, 3'd3, 1);
    lockRun("R6 mac xfer",   CO, 3'd4, 0);
    lockRun("R7 class 5",    CO, 3'd5, 0);
    lockRun("R7 class 7",    CO, 3'd7, 0);
    lockRun("R8 abr slot A", AB, 3'd0, 1);

    // R8: ABR issued from slot B also locks the next cycle
    @(negedge clk);
    vldA = 1'b1; grpA = EX; clsA = 3'd0; vldB = 1'b1; grpB = AB;
    #1;
    check("R8 abr slot B pairs", issueSecond, 1);
    @(negedge clk);
    vldB = 1'b0; grpA = MT;
    #1;
    check("R8 abr slot B stall", stall, 1);
    check("R9 blocked while stalled", issueFirst, 0);
    @(negedge clk); #1;
    check("R8 abr lock one cycle", stall, 0);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule